// File: doc/BRIEF.md
# Accumulator ALU with decimal adjust

This execution unit serves a small accumulator-based controller. It carries out three single-operand instructions on one byte read from data memory: a one's-complement that loads the accumulator, a decimal adjust of the accumulator that stores its result into memory, and a decrement of the memory byte in place. Instruction fetch, address decode and the memory array belong to the surrounding core.

The core presents an opcode, a one-cycle start strobe, the current accumulator, the memory byte at the addressed location and the incoming zero, auxiliary-carry and carry flags. One clock later the unit raises a write enable for the accumulator or for memory, together with the value to write and the updated flags. The decimal adjust treats each nibble on its own. A carry out of the low nibble is dropped. The adjust can set the carry flag but never clears it.

Top module: `acc_alu`

## Requirements
- R1: With opcode 2'b00 (complement), acc_o becomes the bitwise inverse of mem_i and acc_we_o is asserted. mem_we_o stays low, so the memory byte is not written.
- R2: After complement, flag_z_o is 1 exactly when the inverted byte is 0x00. flag_ac_o and flag_c_o equal the incoming flag_ac_i and flag_c_i.
- R3: With opcode 2'b01 (decimal adjust), result bits 3..0 are acc_i[3:0]+6 modulo 16 when acc_i[3:0] > 9 or flag_ac_i is 1. Otherwise they are acc_i[3:0]. No carry passes into the upper nibble.
- R4: In decimal adjust, result bits 7..4 are acc_i[7:4]+6 modulo 16 when acc_i[7:4] > 9 or flag_c_i is 1, and flag_c_o is then 1. Otherwise the upper nibble is copied and flag_c_o equals flag_c_i.
- R5: Decimal adjust writes its result to mem_o with mem_we_o high and acc_we_o low. flag_z_o and flag_ac_o equal their inputs, and the carry is never cleared.
- R6: With opcode 2'b10 (decrement), mem_o becomes mem_i-1 modulo 256 (0x00 gives 0xFF) with mem_we_o high. flag_z_o is 1 exactly when the result is 0x00. AC and C pass through unchanged.
- R7: Results appear on the clock edge after the edge that sees start_i high. For each valid opcode exactly one write enable is high, for that one cycle only. Without start_i no write enable is asserted and the flag outputs hold their values.
- R8: Opcode 2'b11 is reserved. On start it asserts neither write enable, and the flag outputs take the incoming flags unchanged.
- R9: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle execute strobe |
| op_i | input | 2 | Opcode: 00 complement, 01 decimal adjust, 10 decrement, 11 reserved |
| acc_i | input | 8 | Current accumulator |
| mem_i | input | 8 | Byte read at the addressed location |
| flag_z_i | input | 1 | Incoming zero flag |
| flag_ac_i | input | 1 | Incoming auxiliary carry |
| flag_c_i | input | 1 | Incoming carry |
| acc_we_o | output | 1 | Accumulator write enable |
| acc_o | output | 8 | Accumulator write value |
| mem_we_o | output | 1 | Memory write enable |
| mem_o | output | 8 | Memory write value |
| flag_z_o | output | 1 | Updated zero flag |
| flag_ac_o | output | 1 | Updated auxiliary carry |
| flag_c_o | output | 1 | Updated carry |

## Verification
The unit holds state only in one output register stage, so a wrong value shows at the ports on the cycle right after the start strobe. A bad opcode decode shows as the wrong write enable or as two enables together. A nibble adjust error shows as a wrong digit in mem_o. A flag that should pass through but gets updated shows as a changed flag_ac_o or flag_c_o. The decimal adjust cases cover each nibble above nine, each one forced by its flag, and the 0xF+6 wrap. They show a carry wrongly passed into the upper nibble, and a carry cleared by the adjust when it should have been kept.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [1:0] {
    OP_CPL = 2'b00,
    OP_DAA = 2'b01,
    OP_DEC = 2'b10,
    OP_NOP = 2'b11
  } op_e;

  typedef struct packed {
    logic z;
    logic ac;
    logic c;
  } flags_t;
endpackage

// File: rtl/acc_alu_cpl.sv
module acc_alu_cpl #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] mem_i,
  output logic [DW-1:0] res_o,
  output logic          z_o
);
  assign res_o = ~mem_i;
  assign z_o   = ~|res_o;
endmodule

// File: rtl/acc_alu_dec.sv
module acc_alu_dec #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] mem_i,
  output logic [DW-1:0] res_o,
  output logic          z_o
);
  assign res_o = mem_i - DW'(1);
  assign z_o   = ~|res_o;
endmodule

// File: rtl/acc_alu_daa.sv
module acc_alu_daa #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] acc_i,
  input  logic          ac_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  localparam int unsigned NIB = DW / 4;

  logic [NIB-1:0] adj;

  for (genvar g = 0; g < NIB; g++) begin : g_nib
    logic [3:0] n;
    logic       force_adj;
    assign n = acc_i[4*g +: 4];
    if (g == 0) begin : g_lo
      assign force_adj = ac_i;
    end else if (g == NIB - 1) begin : g_hi
      assign force_adj = c_i;
    end else begin : g_mid
      assign force_adj = 1'b0;
    end
    assign adj[g] = (n > 4'd9) | force_adj;
    // nibble sum wraps; no carry into the next nibble
    assign res_o[4*g +: 4] = adj[g] ? n + 4'd6 : n;
  end

  assign c_o = adj[NIB-1] | c_i;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mem_i,
  input  logic          flag_z_i,
  input  logic          flag_ac_i,
  input  logic          flag_c_i,
  output logic          acc_we_o,
  output logic [DW-1:0] acc_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_o,
  output logic          flag_z_o,
  output logic          flag_ac_o,
  output logic          flag_c_o
);
  logic [DW-1:0] cpl_res, daa_res, dec_res;
  logic          cpl_z, dec_z, daa_c;

  acc_alu_cpl #(.DW(DW)) i_cpl (.mem_i(mem_i), .res_o(cpl_res), .z_o(cpl_z));
  acc_alu_dec #(.DW(DW)) i_dec (.mem_i(mem_i), .res_o(dec_res), .z_o(dec_z));
  acc_alu_daa #(.DW(DW)) i_daa (
    .acc_i(acc_i), .ac_i(flag_ac_i), .c_i(flag_c_i), .res_o(daa_res), .c_o(daa_c)
  );

  flags_t        flg_in, flg_nxt, flg_q;
  logic          acc_we_nxt, mem_we_nxt;
  logic [DW-1:0] acc_nxt, mem_nxt;
  logic [DW-1:0] acc_q, mem_q;
  logic          acc_we_q, mem_we_q;

  assign flg_in = '{z: flag_z_i, ac: flag_ac_i, c: flag_c_i};

  always_comb begin
    flg_nxt    = flg_q;
    acc_nxt    = acc_q;
    mem_nxt    = mem_q;
    acc_we_nxt = 1'b0;
    mem_we_nxt = 1'b0;
    if (start_i) begin
      flg_nxt = flg_in;
      unique case (op_e'(op_i))
        OP_CPL: begin
          acc_nxt    = cpl_res;
          acc_we_nxt = 1'b1;
          flg_nxt.z  = cpl_z;
        end
        OP_DAA: begin
          mem_nxt    = daa_res;
          mem_we_nxt = 1'b1;
          flg_nxt.c  = daa_c;
        end
        OP_DEC: begin
          mem_nxt    = dec_res;
          mem_we_nxt = 1'b1;
          flg_nxt.z  = dec_z;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q    <= '0;
      acc_q    <= '0;
      mem_q    <= '0;
      acc_we_q <= 1'b0;
      mem_we_q <= 1'b0;
    end else begin
      flg_q    <= flg_nxt;
      acc_q    <= acc_nxt;
      mem_q    <= mem_nxt;
      acc_we_q <= acc_we_nxt;
      mem_we_q <= mem_we_nxt;
    end
  end

  assign acc_we_o  = acc_we_q;
  assign mem_we_o  = mem_we_q;
  assign acc_o     = acc_q;
  assign mem_o     = mem_q;
  assign flag_z_o  = flg_q.z;
  assign flag_ac_o = flg_q.ac;
  assign flag_c_o  = flg_q.c;

  assert_one_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_i != OP_NOP |=> $countones({acc_we_o, mem_we_o}) == 1);
  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !acc_we_o && !mem_we_o && $stable({flag_z_o, flag_ac_o, flag_c_o}));
  assert_cpl_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_i == OP_CPL |=> flag_ac_o == $past(flag_ac_i) && flag_c_o == $past(flag_c_i));
  assert_daa_c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_i == OP_DAA && flag_c_i |=> flag_c_o && mem_we_o);
  assert_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_i == OP_DEC |=> mem_o == $past(mem_i) - DW'(1));
  assert_nop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_i == OP_NOP |=> !acc_we_o && !mem_we_o);
endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] acc = '0, mem = '0;
  logic       z_i = 1'b0, ac_i = 1'b0, c_i = 1'b0;
  logic       acc_we, mem_we, z_o, ac_o, c_o;
  logic [7:0] acc_o, mem_o;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acc_alu i_acc_alu (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .op_i(op), .acc_i(acc), .mem_i(mem),
    .flag_z_i(z_i), .flag_ac_i(ac_i), .flag_c_i(c_i),
    .acc_we_o(acc_we), .acc_o(acc_o), .mem_we_o(mem_we), .mem_o(mem_o),
    .flag_z_o(z_o), .flag_ac_o(ac_o), .flag_c_o(c_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, one start cycle, sample at following negedge
  task automatic issue(logic [1:0] o, logic [7:0] a, logic [7:0] m, logic z, logic ac, logic c);
    @(negedge clk);
    op = o; acc = a; mem = m; z_i = z; ac_i = ac; c_i = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 acc_we", acc_we, 0); chk("R9 mem_we", mem_we, 0);
    chk("R9 acc", acc_o, 0); chk("R9 mem", mem_o, 0);
    chk("R9 flags", {z_o, ac_o, c_o}, 0);
  endtask

  task automatic t_cpl;
    issue(2'b00, 8'h33, 8'h5A, 1'b1, 1'b1, 1'b0);
    chk("R1 acc", acc_o, 8'hA5); chk("R1 we", {acc_we, mem_we}, 2'b10);
    chk("R2 flags", {z_o, ac_o, c_o}, 3'b010);
    issue(2'b00, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1);
    chk("R1 acc zero", acc_o, 8'h00); chk("R2 z set", {z_o, ac_o, c_o}, 3'b101);
  endtask

  task automatic t_daa(logic [7:0] a, logic ac, logic c, logic z, logic [7:0] exp, logic exp_c, string req);
    issue(2'b01, a, 8'h77, z, ac, c);
    chk({req, " mem"}, mem_o, exp);
    chk("R5 we", {acc_we, mem_we}, 2'b01);
    chk({req, " flags"}, {z_o, ac_o, c_o}, {z, ac, exp_c});
  endtask

  task automatic t_dec;
    issue(2'b10, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1);
    chk("R6 mem", mem_o, 8'h00); chk("R6 flags", {z_o, ac_o, c_o}, 3'b111);
    chk("R6 we", {acc_we, mem_we}, 2'b01);
    issue(2'b10, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R6 wrap", mem_o, 8'hFF); chk("R6 z clr", z_o, 0);
    issue(2'b10, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0);
    chk("R6 mid", mem_o, 8'h7F);
  endtask

  task automatic t_timing;
    issue(2'b10, 8'h00, 8'h10, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7 we drops", {acc_we, mem_we}, 2'b00);
    z_i = 1'b1; ac_i = 1'b1; c_i = 1'b0;
    @(negedge clk);
    chk("R7 flags hold", {z_o, ac_o, c_o}, 3'b001);
  endtask

  task automatic t_nop;
    issue(2'b11, 8'h12, 8'h34, 1'b1, 1'b0, 1'b1);
    chk("R8 we", {acc_we, mem_we}, 2'b00);
    chk("R8 flags", {z_o, ac_o, c_o}, 3'b101);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_cpl();
    t_daa(8'h9A, 1'b0, 1'b0, 1'b1, 8'h90, 1'b0, "R3 lo>9 no carry up");
    t_daa(8'h45, 1'b1, 1'b0, 1'b0, 8'h4B, 1'b0, "R3 ac forced");
    t_daa(8'h27, 1'b0, 1'b0, 1'b0, 8'h27, 1'b0, "R3 no adjust");
    t_daa(8'hA3, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, "R4 hi>9");
    t_daa(8'h12, 1'b0, 1'b1, 1'b1, 8'h72, 1'b1, "R4 c forced");
    t_daa(8'hFF, 1'b0, 1'b0, 1'b0, 8'h55, 1'b1, "R4 both wrap");
    t_daa(8'h11, 1'b0, 1'b1, 1'b0, 8'h71, 1'b1, "R5 c kept");
    t_dec();
    t_timing();
    t_nop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule